// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block keeps the in-flight loads of an out-of-order core in a circular queue, oldest at the head. Each dispatched load takes a slot at the tail and is tagged with its sequence number and with the store-queue tail index current at dispatch. Once the load computes its effective address, the address is written into its slot.

When a store computes its address, the core starts a check. The check gives the load-queue index recorded by that store, which is the first load younger than it. A scan engine then visits one slot per cycle, from that index up to the live tail. A load whose recorded address falls in the same coarse block as the store address has read too early. The oldest such load is held in a violator register, which the core reads and clears with an acknowledge.

Commit retires every load up to a given sequence number in one cycle. A branch flush removes, in one cycle, every load younger than a given sequence number from the tail end of the queue. Sequence numbers grow in program order and do not wrap.

Top module: `load_order_queue`

## Requirements
- R1: After reset the queue is empty (head_valid=0, lq_full=0, alloc_idx=0), no violator is held (viol_valid=0) and a check can be accepted (chk_ready=1).
- R2: An accepted allocation places the load in slot alloc_idx, which is the current tail. Successive loads take successive slots. head_seq and head_sq_tail show the sequence number and the store-tail snapshot of the oldest load.
- R3: The queue has CAP usable entries out of CAP+1 slots. lq_full is 1 exactly when the slot after the tail is the head. An allocation is ignored (tail unchanged) when lq_full is 1, or when commit_valid or squash_valid is high in the same cycle.
- R4: An address update for an occupied slot records the address and marks it valid. A load with no recorded address never conflicts, whatever its slot holds.
- R5: A check is accepted only when chk_ready=1. It then inspects one slot per cycle, starting at chk_idx and stopping at the first slot outside the occupied range, which is the tail in the normal case. chk_ready stays 0 until the scan ends, and a check that starts at the tail ends without inspecting any slot.
- R6: A load conflicts with the store when (load address >> BLK_SHIFT) equals (store address >> BLK_SHIFT). BLK_SHIFT is 8 by default, so addresses in different 256-byte blocks never conflict.
- R7: The violator register keeps the conflicting load with the smallest sequence number. A result is loaded when the scan ends, and only when the register is empty or the new load is older.
- R8: A cycle with viol_ack=1 clears the held violator. If a scan ends in that same cycle, its result is loaded.
- R9: Commit with number N frees every load from the head whose sequence number is <= N, stopping at the first younger load or when the queue is empty.
- R10: Squash with number N removes every load from the tail end whose sequence number is > N. The removed slots are reused by the next allocations.
- R11: Squash with number N clears a held violator whose sequence number is > N. It also drops any conflict found by a scan in progress on a load with a sequence number > N.
- R12: Slot indices advance from CAP to 0 and step back from 0 to CAP. Allocation, commit and scans cross that boundary without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a dispatched load |
| alloc_seq | input | SEQ_W | Sequence number of the load |
| alloc_sq_tail | input | SQ_IDX_W | Store-queue tail index at dispatch |
| alloc_idx | output | IDX_W | Slot the next allocation takes (the tail) |
| lq_full | output | 1 | No free slot |
| addr_valid | input | 1 | Record an effective address |
| addr_idx | input | IDX_W | Slot of the executed load |
| addr_value | input | ADDR_W | Effective address of that load |
| chk_valid | input | 1 | Start a store ordering check |
| chk_ready | output | 1 | Scan engine idle |
| chk_idx | input | IDX_W | First load slot younger than the store |
| chk_addr | input | ADDR_W | Effective address of the store |
| commit_valid | input | 1 | Retire loads up to commit_seq |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Flush loads younger than squash_seq |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| head_valid | output | 1 | Queue not empty |
| head_seq | output | SEQ_W | Sequence number of the oldest load |
| head_sq_tail | output | SQ_IDX_W | Store-tail snapshot of the oldest load |
| viol_valid | output | 1 | A violating load is held |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_ack | input | 1 | Consume and clear the violator |

## Verification
The bench builds the queue with CAP=5, which gives six slots. With a slot count that is not a power of two, the index wrap from 5 back to 0 is reached after a handful of allocations, and a scan is run across it. The small capacity lets the full state be reached within the table. That covers allocations refused while full and refused while a commit runs in the same cycle. The default 16-bit sequence, 32-bit address and 8-bit block shift are kept, so the one-block-apart miss is tested at the 256-byte boundary. A flush landing in the middle of a scan is run and then repeated without the flush, to show the scan alone would have found the load.

// File: rtl/lq_pkg.sv
package lq_pkg;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_ALLOC,
        PTR_COMMIT,
        PTR_SQUASH
    } ptr_op_e;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_state_e;

    function automatic int unsigned wrap_inc(int unsigned i, int unsigned n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

    function automatic int unsigned wrap_dec(int unsigned i, int unsigned n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

    function automatic int unsigned wrap_add(int unsigned i, int unsigned k, int unsigned n);
        int unsigned s;
        s = i + k;
        return (s >= n) ? s - n : s;
    endfunction

    function automatic int unsigned age_of(int unsigned i, int unsigned head, int unsigned n);
        return (i >= head) ? i - head : i + n - head;
    endfunction

    function automatic logic same_block(logic [63:0] a, logic [63:0] b, int unsigned sh);
        return (a >> sh) == (b >> sh);
    endfunction

endpackage

// File: rtl/lq_age_find.sv
module lq_age_find #(
    parameter int SLOTS = 9,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [IDX_W-1:0]            cnt,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [SEQ_W-1:0]            limit,
    output logic [IDX_W-1:0]            off
);
    import lq_pkg::*;

    // Age offset of the first live entry younger than limit; cnt if none.
    always_comb begin
        logic found;
        found = 1'b0;
        off   = cnt;
        for (int k = 0; k < SLOTS; k++) begin
            if (!found && k < int'(cnt) &&
                seqs[wrap_add(32'(head), k, SLOTS)] > limit) begin
                off   = IDX_W'(k);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lq_scan.sv
module lq_scan #(
    parameter int SLOTS     = 9,
    parameter int IDX_W     = 4,
    parameter int SEQ_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [IDX_W-1:0]  head,
    input  logic [IDX_W-1:0]  cnt,
    input  logic [SEQ_W-1:0]  e_seq,
    input  logic              e_av,
    input  logic [ADDR_W-1:0] e_addr,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              busy,
    output logic [IDX_W-1:0]  ptr,
    output logic              done,
    output logic              hit,
    output logic [SEQ_W-1:0]  hit_seq,
    output logic [IDX_W-1:0]  hit_idx
);
    import lq_pkg::*;

    scan_state_e       state_q, state_n;
    logic [IDX_W-1:0]  ptr_q, ptr_n;
    logic [ADDR_W-1:0] st_addr_q, st_addr_n;
    logic              hit_q, hit_n;
    logic [SEQ_W-1:0]  hseq_q, hseq_n;
    logic [IDX_W-1:0]  hidx_q, hidx_n;
    logic              in_range;
    logic              match;

    assign in_range = age_of(32'(ptr_q), 32'(head), SLOTS) < 32'(cnt);
    assign match    = e_av &&
                      same_block(64'(e_addr), 64'(st_addr_q), BLK_SHIFT) &&
                      !(squash_valid && e_seq > squash_seq);

    always_comb begin
        state_n   = state_q;
        ptr_n     = ptr_q;
        st_addr_n = st_addr_q;
        hit_n     = hit_q;
        hseq_n    = hseq_q;
        hidx_n    = hidx_q;
        case (state_q)
            SCAN_IDLE: begin
                if (chk_valid) begin
                    state_n   = SCAN_RUN;
                    ptr_n     = chk_idx;
                    st_addr_n = chk_addr;
                    hit_n     = 1'b0;
                end
            end
            default: begin
                if (in_range) begin
                    ptr_n = IDX_W'(wrap_inc(32'(ptr_q), SLOTS));
                    // entries are visited oldest first: the first hit is the oldest
                    if (!hit_q && match) begin
                        hit_n  = 1'b1;
                        hseq_n = e_seq;
                        hidx_n = ptr_q;
                    end
                end else begin
                    state_n = SCAN_IDLE;
                end
            end
        endcase
        if (squash_valid && hit_q && hseq_q > squash_seq) begin
            hit_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            ptr_q   <= '0;
            hit_q   <= 1'b0;
            hseq_q  <= '0;
            hidx_q  <= '0;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
            hit_q   <= hit_n;
            hseq_q  <= hseq_n;
            hidx_q  <= hidx_n;
        end
    end

    always_ff @(posedge clk) begin
        st_addr_q <= st_addr_n;
    end

    assign busy    = (state_q == SCAN_RUN);
    assign ptr     = ptr_q;
    assign done    = (state_q == SCAN_RUN) && !in_range;
    assign hit     = hit_q;
    assign hit_seq = hseq_q;
    assign hit_idx = hidx_q;

    AST_SCAN_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        chk_valid && state_q == SCAN_IDLE |=> state_q == SCAN_RUN); // R5

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        state_q == SCAN_RUN |-> 32'(ptr_q) < SLOTS); // R12

endmodule

// File: rtl/lq_viol.sv
module lq_viol #(
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic             hit,
    input  logic [SEQ_W-1:0] hit_seq,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             ack,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             v,
    output logic [SEQ_W-1:0] seq,
    output logic [IDX_W-1:0] idx
);
    logic             v_q, v_n, base_v, take;
    logic [SEQ_W-1:0] seq_q, seq_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    always_comb begin
        base_v = v_q && !ack;
        take   = done && hit && (!base_v || hit_seq < seq_q);
        v_n    = take || base_v;
        seq_n  = take ? hit_seq : seq_q;
        idx_n  = take ? hit_idx : idx_q;
        if (squash_valid && squash_seq < seq_n) begin
            v_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= 1'b0;
            seq_q <= '0;
            idx_q <= '0;
        end else begin
            v_q   <= v_n;
            seq_q <= seq_n;
            idx_q <= idx_n;
        end
    end

    assign v   = v_q;
    assign seq = seq_q;
    assign idx = idx_q;

    AST_VIOL_OLDER: assert property (@(posedge clk) disable iff (rst)
        v_q && $past(v_q) && !$past(ack) |-> seq_q <= $past(seq_q)); // R7

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ack && v_q && !(done && hit) |=> !v_q); // R8

    AST_SQUASH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> !v_q || seq_q <= $past(squash_seq)); // R11

endmodule

// File: rtl/load_order_queue.sv
module load_order_queue #(
    parameter int CAP       = 8,
    parameter int SEQ_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int SQ_IDX_W  = 4,
    parameter int BLK_SHIFT = 8,
    localparam int SLOTS    = CAP + 1,
    localparam int IDX_W    = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
    output logic [IDX_W-1:0]    alloc_idx,
    output logic                lq_full,
    input  logic                addr_valid,
    input  logic [IDX_W-1:0]    addr_idx,
    input  logic [ADDR_W-1:0]   addr_value,
    input  logic                chk_valid,
    output logic                chk_ready,
    input  logic [IDX_W-1:0]    chk_idx,
    input  logic [ADDR_W-1:0]   chk_addr,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    output logic                head_valid,
    output logic [SEQ_W-1:0]    head_seq,
    output logic [SQ_IDX_W-1:0] head_sq_tail,
    output logic                viol_valid,
    output logic [SEQ_W-1:0]    viol_seq,
    output logic [IDX_W-1:0]    viol_idx,
    input  logic                viol_ack
);
    import lq_pkg::*;

    logic [IDX_W-1:0] head_q, tail_q, cnt_q;
    logic [SLOTS-1:0][SEQ_W-1:0]    seq_all;
    logic [SLOTS-1:0][SQ_IDX_W-1:0] sqt_all;
    logic [SLOTS-1:0]               av_all;
    logic [SLOTS-1:0][ADDR_W-1:0]   addr_all;

    logic             alloc_fire;
    logic             addr_live;
    logic [SEQ_W-1:0] cut_seq;
    logic [IDX_W-1:0] cut_off;
    logic [SEQ_W-1:0] tail_seq;
    ptr_op_e          op;

    logic             scan_busy, scan_done, scan_hit;
    logic [IDX_W-1:0] scan_ptr, scan_hit_idx;
    logic [SEQ_W-1:0] scan_hit_seq;

    assign lq_full    = (IDX_W'(wrap_inc(32'(tail_q), SLOTS)) == head_q);
    assign alloc_fire = alloc_valid && !lq_full && !commit_valid && !squash_valid;
    assign addr_live  = age_of(32'(addr_idx), 32'(head_q), SLOTS) < 32'(cnt_q);
    assign cut_seq    = squash_valid ? squash_seq : commit_seq;

    always_comb begin
        if (squash_valid)      op = PTR_SQUASH;
        else if (commit_valid) op = PTR_COMMIT;
        else if (alloc_fire)   op = PTR_ALLOC;
        else                   op = PTR_HOLD;
    end

    // ---------------- per-slot storage ----------------
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [SEQ_W-1:0]    seq_r;
        logic [SQ_IDX_W-1:0] sqt_r;
        logic                av_r;
        logic [ADDR_W-1:0]   addr_r;
        logic                alloc_here, addr_here;

        assign alloc_here = alloc_fire && (tail_q == IDX_W'(s));
        assign addr_here  = addr_valid && addr_live && (addr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (alloc_here) begin
                seq_r <= alloc_seq;
                sqt_r <= alloc_sq_tail;
            end
            if (addr_here) begin
                addr_r <= addr_value;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)             av_r <= 1'b0;
            else if (alloc_here) av_r <= 1'b0;
            else if (addr_here)  av_r <= 1'b1;
        end

        assign seq_all[s]  = seq_r;
        assign sqt_all[s]  = sqt_r;
        assign av_all[s]   = av_r;
        assign addr_all[s] = addr_r;
    end

    // ---------------- commit / squash boundary ----------------
    lq_age_find #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_find (
        .head  (head_q),
        .cnt   (cnt_q),
        .seqs  (seq_all),
        .limit (cut_seq),
        .off   (cut_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (op)
                PTR_SQUASH: begin
                    tail_q <= IDX_W'(wrap_add(32'(head_q), 32'(cut_off), SLOTS));
                    cnt_q  <= cut_off;
                end
                PTR_COMMIT: begin
                    head_q <= IDX_W'(wrap_add(32'(head_q), 32'(cut_off), SLOTS));
                    cnt_q  <= cnt_q - cut_off;
                end
                PTR_ALLOC: begin
                    tail_q <= IDX_W'(wrap_inc(32'(tail_q), SLOTS));
                    cnt_q  <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- store ordering scan ----------------
    lq_scan #(
        .SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W),
        .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)
    ) u_scan (
        .clk          (clk),
        .rst          (rst),
        .chk_valid    (chk_valid),
        .chk_idx      (chk_idx),
        .chk_addr     (chk_addr),
        .head         (head_q),
        .cnt          (cnt_q),
        .e_seq        (seq_all[scan_ptr]),
        .e_av         (av_all[scan_ptr]),
        .e_addr       (addr_all[scan_ptr]),
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .busy         (scan_busy),
        .ptr          (scan_ptr),
        .done         (scan_done),
        .hit          (scan_hit),
        .hit_seq      (scan_hit_seq),
        .hit_idx      (scan_hit_idx)
    );

    lq_viol #(.SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_viol (
        .clk          (clk),
        .rst          (rst),
        .done         (scan_done),
        .hit          (scan_hit),
        .hit_seq      (scan_hit_seq),
        .hit_idx      (scan_hit_idx),
        .ack          (viol_ack),
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .v            (viol_valid),
        .seq          (viol_seq),
        .idx          (viol_idx)
    );

    assign chk_ready    = !scan_busy;
    assign alloc_idx    = tail_q;
    assign head_valid   = (cnt_q != '0);
    assign head_seq     = seq_all[head_q];
    assign head_sq_tail = sqt_all[head_q];
    assign tail_seq     = seq_all[IDX_W'(wrap_dec(32'(tail_q), SLOTS))];

    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt_q) == CAP) == lq_full); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && lq_full && !commit_valid && !squash_valid |=> $stable(tail_q)); // R3

    AST_COMMIT_HEAD: assert property (@(posedge clk) disable iff (rst)
        commit_valid && !squash_valid |=> cnt_q == '0 || head_seq > $past(commit_seq)); // R9

    AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> cnt_q == '0 || tail_seq <= $past(squash_seq)); // R10

endmodule

// File: tb/load_order_queue_test.sv
`timescale 1ns/1ps
module load_order_queue_test;

    localparam int CAP = 5;
    localparam int IW  = 3;

    localparam logic [3:0] OP_ALLOC  = 4'd1;
    localparam logic [3:0] OP_ADDR   = 4'd2;
    localparam logic [3:0] OP_CHECK  = 4'd3;
    localparam logic [3:0] OP_ACK    = 4'd4;
    localparam logic [3:0] OP_PEEK   = 4'd5;
    localparam logic [3:0] OP_COMMIT = 4'd6;
    localparam logic [3:0] OP_SQUASH = 4'd7;
    localparam logic [3:0] OP_HEADSQ = 4'd8;

    // {op, req, a, b, exp_valid, exp_value}
    localparam int NV = 30;
    localparam logic [72:0] VEC [NV] = '{
        {OP_ALLOC,  4'd2,  16'd10, 32'd1,          1'b0, 16'd0},  // R2
        {OP_ALLOC,  4'd2,  16'd11, 32'd1,          1'b0, 16'd1},  // R2
        {OP_ALLOC,  4'd2,  16'd12, 32'd2,          1'b0, 16'd2},  // R2
        {OP_ALLOC,  4'd2,  16'd13, 32'd2,          1'b0, 16'd3},  // R2
        {OP_HEADSQ, 4'd2,  16'd0,  32'd0,          1'b0, 16'd1},  // R2
        {OP_ADDR,   4'd4,  16'd1,  32'h1000_0010,  1'b0, 16'd0},  // R4
        {OP_ADDR,   4'd4,  16'd2,  32'h1000_00F0,  1'b0, 16'd0},  // R4
        {OP_ADDR,   4'd4,  16'd3,  32'h2000_0000,  1'b0, 16'd0},  // R4
        {OP_CHECK,  4'd5,  16'd0,  32'h1000_00FF,  1'b1, 16'd11}, // R5
        {OP_CHECK,  4'd7,  16'd2,  32'h1000_0000,  1'b1, 16'd11}, // R7
        {OP_ACK,    4'd8,  16'd0,  32'd0,          1'b0, 16'd0},  // R8
        {OP_CHECK,  4'd5,  16'd2,  32'h1000_0000,  1'b1, 16'd12}, // R5
        {OP_CHECK,  4'd6,  16'd0,  32'h1000_0100,  1'b1, 16'd12}, // R6
        {OP_ACK,    4'd8,  16'd0,  32'd0,          1'b0, 16'd0},  // R8
        {OP_CHECK,  4'd6,  16'd0,  32'h3000_0000,  1'b0, 16'd0},  // R6
        {OP_CHECK,  4'd4,  16'd0,  32'h0000_0000,  1'b0, 16'd0},  // R4
        {OP_CHECK,  4'd6,  16'd3,  32'h2000_00AB,  1'b1, 16'd13}, // R6
        {OP_SQUASH, 4'd10, 16'd12, 32'd0,          1'b1, 16'd10}, // R10
        {OP_PEEK,   4'd11, 16'd0,  32'd0,          1'b0, 16'd0},  // R11
        {OP_ALLOC,  4'd10, 16'd20, 32'd3,          1'b0, 16'd3},  // R10
        {OP_COMMIT, 4'd9,  16'd11, 32'd0,          1'b1, 16'd12}, // R9
        {OP_HEADSQ, 4'd2,  16'd0,  32'd0,          1'b0, 16'd2},  // R2
        {OP_ALLOC,  4'd12, 16'd21, 32'd3,          1'b0, 16'd4},  // R12
        {OP_ALLOC,  4'd12, 16'd22, 32'd3,          1'b0, 16'd5},  // R12
        {OP_ALLOC,  4'd12, 16'd23, 32'd4,          1'b0, 16'd0},  // R12
        {OP_ADDR,   4'd4,  16'd5,  32'h5000_0000,  1'b0, 16'd0},  // R4
        {OP_ADDR,   4'd4,  16'd0,  32'h5000_0001,  1'b0, 16'd0},  // R4
        {OP_CHECK,  4'd12, 16'd5,  32'h5000_0080,  1'b1, 16'd22}, // R12
        {OP_ACK,    4'd8,  16'd0,  32'd0,          1'b0, 16'd0},  // R8
        {OP_CHECK,  4'd5,  16'd1,  32'h5000_0000,  1'b0, 16'd0}   // R5
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_valid = 1'b0;
    logic [15:0]   alloc_seq = '0;
    logic [3:0]    alloc_sq_tail = '0;
    logic [IW-1:0] alloc_idx;
    logic          lq_full;
    logic          addr_valid = 1'b0;
    logic [IW-1:0] addr_idx = '0;
    logic [31:0]   addr_value = '0;
    logic          chk_valid = 1'b0;
    logic          chk_ready;
    logic [IW-1:0] chk_idx = '0;
    logic [31:0]   chk_addr = '0;
    logic          commit_valid = 1'b0;
    logic [15:0]   commit_seq = '0;
    logic          squash_valid = 1'b0;
    logic [15:0]   squash_seq = '0;
    logic          head_valid;
    logic [15:0]   head_seq;
    logic [3:0]    head_sq_tail;
    logic          viol_valid;
    logic [15:0]   viol_seq;
    logic [IW-1:0] viol_idx;
    logic          viol_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    load_order_queue #(.CAP(CAP)) uut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_sq_tail(alloc_sq_tail),
        .alloc_idx(alloc_idx), .lq_full(lq_full),
        .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
        .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_idx(chk_idx), .chk_addr(chk_addr),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .head_valid(head_valid), .head_seq(head_seq), .head_sq_tail(head_sq_tail),
        .viol_valid(viol_valid), .viol_seq(viol_seq), .viol_idx(viol_idx),
        .viol_ack(viol_ack)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 50 && !chk_ready; n++) step();
    endtask

    task automatic do_alloc(input logic [15:0] s);
        alloc_valid = 1'b1; alloc_seq = s; alloc_sq_tail = 4'd7;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic do_addr(input logic [IW-1:0] i, input logic [31:0] a);
        addr_valid = 1'b1; addr_idx = i; addr_value = a;
        step();
        addr_valid = 1'b0;
    endtask

    task automatic do_check(input logic [IW-1:0] i, input logic [31:0] a);
        chk_valid = 1'b1; chk_idx = i; chk_addr = a;
        step();
        chk_valid = 1'b0;
        wait_idle();
    endtask

    task automatic do_commit(input logic [15:0] n);
        commit_valid = 1'b1; commit_seq = n;
        step();
        commit_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(1, "head_valid after reset", int'(head_valid), 0);
        check(1, "lq_full after reset", int'(lq_full), 0);
        check(1, "viol_valid after reset", int'(viol_valid), 0);
        check(1, "chk_ready after reset", int'(chk_ready), 1);
        check(1, "alloc_idx after reset", int'(alloc_idx), 0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  op, rq;
            logic [15:0] a, ex;
            logic [31:0] b;
            logic        ev;
            {op, rq, a, b, ev, ex} = VEC[i];
            case (op)
                OP_ALLOC: begin
                    alloc_valid = 1'b1; alloc_seq = a; alloc_sq_tail = b[3:0];
                    check(int'(rq), "alloc_idx", int'(alloc_idx), int'(ex));
                    step();
                    alloc_valid = 1'b0;
                end
                OP_ADDR: do_addr(a[IW-1:0], b);
                OP_CHECK: begin
                    do_check(a[IW-1:0], b);
                    check(int'(rq), "viol_valid after check", int'(viol_valid), int'(ev));
                    if (ev) check(int'(rq), "viol_seq after check", int'(viol_seq), int'(ex));
                end
                OP_ACK: begin
                    viol_ack = 1'b1;
                    step();
                    viol_ack = 1'b0;
                    check(int'(rq), "viol_valid after ack", int'(viol_valid), int'(ev));
                end
                OP_PEEK: check(int'(rq), "viol_valid", int'(viol_valid), int'(ev));
                OP_COMMIT, OP_SQUASH: begin
                    if (op == OP_COMMIT) begin
                        commit_valid = 1'b1; commit_seq = a;
                    end else begin
                        squash_valid = 1'b1; squash_seq = a;
                    end
                    step();
                    commit_valid = 1'b0; squash_valid = 1'b0;
                    check(int'(rq), "head_valid", int'(head_valid), int'(ev));
                    if (ev) check(int'(rq), "head_seq", int'(head_seq), int'(ex));
                end
                OP_HEADSQ: check(int'(rq), "head_sq_tail", int'(head_sq_tail), int'(ex));
                default: ;
            endcase
        end

        // R3: full after CAP live loads, further allocation refused
        check(3, "lq_full at capacity", int'(lq_full), 1);
        do_alloc(16'd24);
        check(3, "tail after refused alloc", int'(alloc_idx), 1);

        // R3: allocation refused when commit shares the cycle
        alloc_valid = 1'b1; alloc_seq = 16'd25;
        commit_valid = 1'b1; commit_seq = 16'd22;
        step();
        alloc_valid = 1'b0; commit_valid = 1'b0;
        check(3, "tail after alloc with commit", int'(alloc_idx), 1);
        check(9, "head_seq after commit 22", int'(head_seq), 23);

        // R9: commit past everything empties the queue
        do_commit(16'd30);
        check(9, "head_valid after full commit", int'(head_valid), 0);

        // R11: squash during a scan drops a conflict not yet reached
        do_alloc(16'd50);
        do_alloc(16'd51);
        do_alloc(16'd52);
        do_addr(3'd3, 32'h7000_0000);
        chk_valid = 1'b1; chk_idx = 3'd1; chk_addr = 32'h7000_0000;
        step();
        chk_valid = 1'b0;
        check(5, "chk_ready while scanning", int'(chk_ready), 0);
        squash_valid = 1'b1; squash_seq = 16'd50;
        step();
        squash_valid = 1'b0;
        wait_idle();
        check(11, "viol_valid after mid-scan squash", int'(viol_valid), 0);
        check(10, "tail after squash to 50", int'(alloc_idx), 2);

        // R6: same scan without the flush finds the load
        do_alloc(16'd51);
        do_alloc(16'd52);
        do_addr(3'd3, 32'h7000_0000);
        do_check(3'd1, 32'h7000_0000);
        check(6, "viol_valid without squash", int'(viol_valid), 1);
        check(6, "viol_seq without squash", int'(viol_seq), 52);
        check(6, "viol_idx without squash", int'(viol_idx), 3);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule